// File: doc/BRIEF.md
# Shadow Translation Buffer with Second-Level Refill

This block is a small, fully associative first-level translation buffer that keeps private copies of page translations held in a larger shared second-level TLB. A requester presents an effective page number together with a process ID. If a valid entry matches both, the block returns the physical page number and a permission field in the same cycle. A hit never touches the second-level TLB, so that structure stays free for other users.

On a miss, the block holds the requester with `busy` and raises a refill request that carries the page number and process ID. It waits for the answer. The returned translation is handed to the requester in the cycle it arrives. It is also written into a slot picked by a round-robin pointer. The pointer moves only when an entry is written and returns to slot 0 on a flush.

A context-synchronizing event clears every entry in one cycle. Such events are an instruction barrier, an interrupt entry, an interrupt return, or a system call. If a refill is still outstanding when the flush happens, its answer is discarded. When translation is disabled for this side, lookups pass straight through and no refill is issued.

Top module: `shadow_tlb`

## Requirements
- R1: With `xlate_en`=1 and `lk_valid`=1, a lookup whose page number and process ID both match a valid entry gives `rsp_vld`=1, `rsp_hit`=1, and that entry's physical page and permission, all combinationally. In that case `busy`=0 and no refill request follows.
- R2: An entry whose page number matches but whose process ID differs does not hit. Likewise, an entry with the same process ID and a different page number does not hit.
- R3: A lookup that misses drives `busy`=1 in that same cycle. From the next cycle, `rf_req`=1 is held with `rf_epn`/`rf_pid` equal to the missed lookup, and `busy` stays 1, until `rf_ack` arrives.
- R4: In the cycle `rf_ack`=1 answers a live refill, `rsp_vld`=1, `rsp_hit`=0, `busy`=0, and `rsp_ppn`/`rsp_perm` equal `rf_ppn`/`rf_perm`. From the next cycle, that translation hits.
- R5: Refills fill slots in round-robin order. After a flush, eight refills fill all eight slots, and the ninth refill evicts the translation loaded first while the others keep hitting.
- R6: `ctx_sync`=1 for one cycle invalidates every entry. Every translation loaded before it misses afterwards.
- R7: If `ctx_sync` is seen while a refill is outstanding, the answering `rf_ack` gives `rsp_vld`=0 and writes nothing. The page still misses afterwards.
- R8: With `xlate_en`=0, a lookup gives `rsp_vld`=1, `rsp_hit`=0, `rsp_ppn` equal to `lk_epn`, `rsp_perm` all ones, and `busy`=0. No refill request is issued.
- R9: `rf_ack` while no refill is outstanding is ignored: no entry is written.
- R10: After reset, `rf_req`=0, `busy`=0, and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlate_en | input | 1 | Translation enable for this side |
| ctx_sync | input | 1 | Context-synchronizing event: flush all entries |
| lk_valid | input | 1 | Lookup present; held until a response while busy |
| lk_epn | input | PAGE_W | Effective page number |
| lk_pid | input | PID_W | Process ID of the access |
| rsp_vld | output | 1 | Translation is available this cycle |
| rsp_hit | output | 1 | Translation came from a resident entry |
| rsp_ppn | output | PAGE_W | Physical page number |
| rsp_perm | output | PERM_W | Permission bits |
| busy | output | 1 | Requester must stall |
| rf_req | output | 1 | Refill request to the second-level TLB |
| rf_epn | output | PAGE_W | Page number of the refill |
| rf_pid | output | PID_W | Process ID of the refill |
| rf_ack | input | 1 | Refill answer valid |
| rf_ppn | input | PAGE_W | Returned physical page |
| rf_perm | input | PERM_W | Returned permission bits |

## Verification
The bench looks for a process-ID mismatch hidden behind a matching page number. A design that compares only page numbers would return another process's translation there. It flushes while a refill is still outstanding, which catches a design that writes the stale answer or reports it as valid. It fills all slots and then one more, to expose a victim pointer that moves on hits or does not wrap, because either would evict the wrong page. It also sends stray acknowledges and lookups with translation disabled. These catch a design that writes junk entries or starts a refill that nobody asked for.

// File: rtl/stlb_pkg.sv
package stlb_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } stlb_state_e;
endpackage

// File: rtl/stlb_cam.sv
module stlb_cam #(
   parameter int ENTRIES = 8,
   parameter int PAGE_W  = 20,
   parameter int PID_W   = 8,
   parameter int PERM_W  = 4,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [PAGE_W-1:0] wr_epn,
   input  logic [PID_W-1:0]  wr_pid,
   input  logic [PAGE_W-1:0] wr_ppn,
   input  logic [PERM_W-1:0] wr_perm,
   input  logic [PAGE_W-1:0] q_epn,
   input  logic [PID_W-1:0]  q_pid,
   output logic              hit,
   output logic [PAGE_W-1:0] hit_ppn,
   output logic [PERM_W-1:0] hit_perm
);
   logic [ENTRIES-1:0] vld_q;
   logic [PAGE_W-1:0]  epn_q  [ENTRIES];
   logic [PID_W-1:0]   pid_q  [ENTRIES];
   logic [PAGE_W-1:0]  ppn_q  [ENTRIES];
   logic [PERM_W-1:0]  perm_q [ENTRIES];
   logic [ENTRIES-1:0] match;
   logic [PAGE_W-1:0]  ppn_or  [ENTRIES+1];
   logic [PERM_W-1:0]  perm_or [ENTRIES+1];

   assign ppn_or[0]  = '0;
   assign perm_or[0] = '0;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[e]  <= 1'b0;
            epn_q[e]  <= '0;
            pid_q[e]  <= '0;
            ppn_q[e]  <= '0;
            perm_q[e] <= '0;
         end else if (flush) begin
            vld_q[e] <= 1'b0;
         end else if (wr_en && wr_idx == IDX_W'(e)) begin
            vld_q[e]  <= 1'b1;
            epn_q[e]  <= wr_epn;
            pid_q[e]  <= wr_pid;
            ppn_q[e]  <= wr_ppn;
            perm_q[e] <= wr_perm;
         end
      end

      assign match[e]     = vld_q[e] && epn_q[e] == q_epn && pid_q[e] == q_pid;
      assign ppn_or[e+1]  = ppn_or[e]  | (match[e] ? ppn_q[e]  : '0);
      assign perm_or[e+1] = perm_or[e] | (match[e] ? perm_q[e] : '0);
   end

   assign hit      = |match;
   assign hit_ppn  = ppn_or[ENTRIES];
   assign hit_perm = perm_or[ENTRIES];

   // R1: a page/process pair is resident in at most one slot
   p_single_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   // R6: a flush leaves no valid slot behind
   p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld_q == '0));
endmodule

// File: rtl/stlb_rr.sv
module stlb_rr #(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);
   logic [IDX_W-1:0] nxt;

   if ((ENTRIES & (ENTRIES - 1)) == 0) begin : g_pow2
      assign nxt = ptr + 1'b1;
   end else begin : g_wrap
      assign nxt = (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr <= '0;
      else if (clr) ptr <= '0;
      else if (adv) ptr <= nxt;
   end

   // R5: victim pointer never leaves the slot range
   p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= IDX_W'(ENTRIES - 1));

   // R5: pointer only moves on a refill write or a flush
   p_ptr_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(ptr));
endmodule

// File: rtl/stlb_ctl.sv
module stlb_ctl
   import stlb_pkg::*;
#(
   parameter int PAGE_W = 20,
   parameter int PID_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss,
   input  logic              ctx_sync,
   input  logic              rf_ack,
   input  logic [PAGE_W-1:0] lk_epn,
   input  logic [PID_W-1:0]  lk_pid,
   output logic              idle,
   output logic              wr_en,
   output logic              busy,
   output logic              rf_req,
   output logic [PAGE_W-1:0] rf_epn,
   output logic [PID_W-1:0]  rf_pid
);
   stlb_state_e state_q;
   logic        drop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         drop_q  <= 1'b0;
         rf_epn  <= '0;
         rf_pid  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (miss && !ctx_sync) begin
                  state_q <= ST_WAIT;
                  drop_q  <= 1'b0;
                  rf_epn  <= lk_epn;
                  rf_pid  <= lk_pid;
               end
            end
            ST_WAIT: begin
               if (rf_ack) begin
                  state_q <= ST_IDLE;
                  drop_q  <= 1'b0;
               end else if (ctx_sync) begin
                  drop_q <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign idle   = (state_q == ST_IDLE);
   assign rf_req = (state_q == ST_WAIT);
   assign wr_en  = rf_req && rf_ack && !drop_q && !ctx_sync;
   assign busy   = (idle && miss) || (rf_req && !wr_en);

   // R3: request fields stay put while the answer is pending
   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_req && !rf_ack) |=> (rf_req && $stable(rf_epn) && $stable(rf_pid)));

   // R7: a flushed refill never gets written
   p_drop_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_req && !rf_ack && ctx_sync) |=> !wr_en);

   // R4: an answered refill closes the request
   p_ack_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_req && rf_ack) |=> !rf_req);
endmodule

// File: rtl/shadow_tlb.sv
module shadow_tlb #(
   parameter int ENTRIES = 8,
   parameter int PAGE_W  = 20,
   parameter int PID_W   = 8,
   parameter int PERM_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xlate_en,
   input  logic              ctx_sync,
   input  logic              lk_valid,
   input  logic [PAGE_W-1:0] lk_epn,
   input  logic [PID_W-1:0]  lk_pid,
   output logic              rsp_vld,
   output logic              rsp_hit,
   output logic [PAGE_W-1:0] rsp_ppn,
   output logic [PERM_W-1:0] rsp_perm,
   output logic              busy,
   output logic              rf_req,
   output logic [PAGE_W-1:0] rf_epn,
   output logic [PID_W-1:0]  rf_pid,
   input  logic              rf_ack,
   input  logic [PAGE_W-1:0] rf_ppn,
   input  logic [PERM_W-1:0] rf_perm
);
   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("shadow_tlb: ENTRIES must be at least 2");
   end
   if (PAGE_W < 1 || PID_W < 1 || PERM_W < 1) begin : g_bad_width
      $error("shadow_tlb: field widths must be positive");
   end

   logic              cam_hit;
   logic [PAGE_W-1:0] cam_ppn;
   logic [PERM_W-1:0] cam_perm;
   logic [IDX_W-1:0]  victim;
   logic              wr_en;
   logic              idle;
   logic              active;
   logic              miss;
   logic              hit_ok;

   assign active = lk_valid && xlate_en;
   assign miss   = active && !cam_hit;
   assign hit_ok = active && cam_hit && idle;

   stlb_cam #(
      .ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .PID_W(PID_W), .PERM_W(PERM_W)
   ) i_cam (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (ctx_sync),
      .wr_en   (wr_en),
      .wr_idx  (victim),
      .wr_epn  (rf_epn),
      .wr_pid  (rf_pid),
      .wr_ppn  (rf_ppn),
      .wr_perm (rf_perm),
      .q_epn   (lk_epn),
      .q_pid   (lk_pid),
      .hit     (cam_hit),
      .hit_ppn (cam_ppn),
      .hit_perm(cam_perm)
   );

   stlb_rr #(.ENTRIES(ENTRIES)) i_rr (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (ctx_sync),
      .adv  (wr_en),
      .ptr  (victim)
   );

   stlb_ctl #(.PAGE_W(PAGE_W), .PID_W(PID_W)) i_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .miss    (miss),
      .ctx_sync(ctx_sync),
      .rf_ack  (rf_ack),
      .lk_epn  (lk_epn),
      .lk_pid  (lk_pid),
      .idle    (idle),
      .wr_en   (wr_en),
      .busy    (busy),
      .rf_req  (rf_req),
      .rf_epn  (rf_epn),
      .rf_pid  (rf_pid)
   );

   always_comb begin
      rsp_vld  = 1'b0;
      rsp_hit  = 1'b0;
      rsp_ppn  = '0;
      rsp_perm = '0;
      if (lk_valid && !xlate_en) begin
         rsp_vld  = 1'b1;
         rsp_ppn  = lk_epn;
         rsp_perm = '1;
      end else if (hit_ok) begin
         rsp_vld  = 1'b1;
         rsp_hit  = 1'b1;
         rsp_ppn  = cam_ppn;
         rsp_perm = cam_perm;
      end else if (lk_valid && wr_en) begin
         rsp_vld  = 1'b1;
         rsp_ppn  = rf_ppn;
         rsp_perm = rf_perm;
      end
   end

   // R8: with translation off and nothing pending, no refill starts
   p_bypass_no_refill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!xlate_en && !rf_req) |=> !rf_req);

   // R1: a resident hit never stalls the requester
   p_hit_no_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_hit) |-> !busy);

   // R3: a stalled requester never sees a response
   p_busy_no_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && xlate_en) |-> !rsp_vld);
endmodule

// File: tb/test_shadow_tlb.sv
module test_shadow_tlb;
   localparam int PW = 20;
   localparam int DW = 8;
   localparam int MW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          xlate_en = 1'b1, ctx_sync = 1'b0, lk_valid = 1'b0;
   logic [PW-1:0] lk_epn = '0;
   logic [DW-1:0] lk_pid = '0;
   logic          rsp_vld, rsp_hit, busy, rf_req;
   logic [PW-1:0] rsp_ppn, rf_epn;
   logic [MW-1:0] rsp_perm;
   logic [DW-1:0] rf_pid;
   logic          rf_ack = 1'b0;
   logic [PW-1:0] rf_ppn = '0;
   logic [MW-1:0] rf_perm = '0;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   shadow_tlb i_shadow_tlb (
      .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .ctx_sync(ctx_sync),
      .lk_valid(lk_valid), .lk_epn(lk_epn), .lk_pid(lk_pid),
      .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm),
      .busy(busy), .rf_req(rf_req), .rf_epn(rf_epn), .rf_pid(rf_pid),
      .rf_ack(rf_ack), .rf_ppn(rf_ppn), .rf_perm(rf_perm)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // side-effect-free probe: lookup is withdrawn before the next rising edge
   task automatic probe(input logic [PW-1:0] e, input logic [DW-1:0] p,
                        input bit exp_hit, input logic [PW-1:0] exp_ppn, input string req);
      @(negedge clk);
      lk_valid = 1'b1; lk_epn = e; lk_pid = p;
      #1;
      chk(rsp_hit == exp_hit, req, 64'(rsp_hit), 64'(exp_hit));
      if (exp_hit) begin
         chk(rsp_vld && rsp_ppn == exp_ppn, req, 64'(rsp_ppn), 64'(exp_ppn));
         chk(!busy, req, 64'(busy), 0);
      end else begin
         chk(busy && !rsp_vld, req, 64'({busy, rsp_vld}), 64'b10);
      end
      lk_valid = 1'b0;
   endtask

   task automatic refill(input logic [PW-1:0] e, input logic [DW-1:0] p,
                         input logic [PW-1:0] ppn, input logic [MW-1:0] perm, input int gap);
      @(negedge clk);
      lk_valid = 1'b1; lk_epn = e; lk_pid = p;
      #1;
      chk(busy && !rsp_vld && !rf_req, "R3 miss stalls", 64'({busy, rsp_vld, rf_req}), 64'b100);
      for (int i = 0; i < gap; i++) begin
         @(negedge clk); #1;
         chk(rf_req && busy, "R3 held", 64'({rf_req, busy}), 64'b11);
      end
      @(negedge clk);
      chk(rf_req && rf_epn == e && rf_pid == p, "R3 request fields",
          64'({rf_req, rf_epn, rf_pid}), 64'({1'b1, e, p}));
      rf_ack = 1'b1; rf_ppn = ppn; rf_perm = perm;
      #1;
      chk(rsp_vld && !rsp_hit && !busy && rsp_ppn == ppn && rsp_perm == perm, "R4 answer",
          64'({rsp_vld, rsp_hit, busy, rsp_ppn, rsp_perm}), 64'({3'b100, ppn, perm}));
      @(negedge clk);
      rf_ack = 1'b0; lk_valid = 1'b0;
   endtask

   task automatic flush();
      @(negedge clk); ctx_sync = 1'b1;
      @(negedge clk); ctx_sync = 1'b0;
   endtask

   // {epn, pid, expected hit, expected ppn}
   localparam int VW = PW + DW + 1 + PW;
   localparam logic [VW-1:0] VEC [10] = '{
      {20'h00010, 8'h01, 1'b1, 20'hA0010},
      {20'h00011, 8'h01, 1'b1, 20'hA0011},
      {20'h00010, 8'h02, 1'b1, 20'hB0010},
      {20'hFFFFF, 8'h01, 1'b1, 20'hCFFFF},
      {20'h00010, 8'h03, 1'b0, 20'h00000},
      {20'h00011, 8'h02, 1'b0, 20'h00000},
      {20'h00012, 8'h01, 1'b0, 20'h00000},
      {20'hFFFFF, 8'h00, 1'b0, 20'h00000},
      {20'h0000F, 8'h01, 1'b0, 20'h00000},
      {20'hFFFFE, 8'h01, 1'b0, 20'h00000}
   };

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: reset state
      #1;
      chk(!rf_req && !busy, "R10 idle after reset", 64'({rf_req, busy}), 0);
      probe(20'h00010, 8'h01, 1'b0, '0, "R10 empty after reset");

      // load four translations, one with a long wait
      refill(20'h00010, 8'h01, 20'hA0010, 4'h3, 0);
      refill(20'h00011, 8'h01, 20'hA0011, 4'h5, 3);
      refill(20'h00010, 8'h02, 20'hB0010, 4'h6, 1);
      refill(20'hFFFFF, 8'h01, 20'hCFFFF, 4'h9, 0);

      // R1 / R2 vector table
      for (int v = 0; v < 10; v++) begin
         logic [VW-1:0] w;
         w = VEC[v];
         probe(w[VW-1 -: PW], w[PW+DW : PW+1], w[PW], w[PW-1:0],
               w[PW] ? "R1 vector hit" : "R2 vector miss");
      end

      // R1: permission returned with a hit, no refill follows
      @(negedge clk);
      lk_valid = 1'b1; lk_epn = 20'h00011; lk_pid = 8'h01;
      #1 chk(rsp_perm == 4'h5, "R1 perm", 64'(rsp_perm), 64'h5);
      @(negedge clk); #1;
      chk(!rf_req && rsp_hit, "R1 no refill on hit", 64'({rf_req, rsp_hit}), 64'b01);
      lk_valid = 1'b0;

      // R8: bypass
      @(negedge clk);
      xlate_en = 1'b0; lk_valid = 1'b1; lk_epn = 20'h12345; lk_pid = 8'h01;
      #1;
      chk(rsp_vld && !rsp_hit && rsp_ppn == 20'h12345 && rsp_perm == 4'hF && !busy,
          "R8 bypass", 64'({rsp_vld, rsp_hit, busy, rsp_ppn, rsp_perm}),
          64'({3'b100, 20'h12345, 4'hF}));
      @(negedge clk); #1;
      chk(!rf_req, "R8 no refill", 64'(rf_req), 0);
      lk_valid = 1'b0; xlate_en = 1'b1;

      // R9: stray ack ignored
      @(negedge clk);
      rf_ack = 1'b1; rf_ppn = 20'h55555; rf_perm = 4'h1;
      @(negedge clk); rf_ack = 1'b0;
      probe(20'h00000, 8'h00, 1'b0, '0, "R9 stray ack wrote nothing");
      probe(20'h00010, 8'h01, 1'b1, 20'hA0010, "R9 contents kept");

      // R6: flush
      flush();
      probe(20'h00010, 8'h01, 1'b0, '0, "R6 flushed a");
      probe(20'h00010, 8'h02, 1'b0, '0, "R6 flushed b");
      probe(20'hFFFFF, 8'h01, 1'b0, '0, "R6 flushed c");

      // R5: round robin over eight slots
      for (int k = 0; k < 8; k++)
         refill(20'h00100 + 20'(k), 8'h03, 20'h80100 + 20'(k), 4'(k), 0);
      for (int k = 0; k < 8; k++)
         probe(20'h00100 + 20'(k), 8'h03, 1'b1, 20'h80100 + 20'(k), "R5 all resident");
      refill(20'h00108, 8'h03, 20'h80108, 4'h8, 0);
      probe(20'h00100, 8'h03, 1'b0, '0, "R5 oldest evicted");
      probe(20'h00101, 8'h03, 1'b1, 20'h80101, "R5 next kept");
      probe(20'h00108, 8'h03, 1'b1, 20'h80108, "R5 newest resident");
      refill(20'h00109, 8'h03, 20'h80109, 4'h9, 0);
      probe(20'h00101, 8'h03, 1'b0, '0, "R5 second evicted");
      probe(20'h00102, 8'h03, 1'b1, 20'h80102, "R5 third kept");

      // R7: flush while refill outstanding
      @(negedge clk);
      lk_valid = 1'b1; lk_epn = 20'h00200; lk_pid = 8'h04;
      @(negedge clk); ctx_sync = 1'b1;
      #1 chk(rf_req, "R7 request pending", 64'(rf_req), 1);
      @(negedge clk); ctx_sync = 1'b0;
      rf_ack = 1'b1; rf_ppn = 20'h90200; rf_perm = 4'h2;
      #1 chk(!rsp_vld && busy, "R7 stale answer dropped", 64'({rsp_vld, busy}), 64'b01);
      @(negedge clk); rf_ack = 1'b0; lk_valid = 1'b0;
      #1 chk(!rf_req, "R7 request closed", 64'(rf_req), 0);
      probe(20'h00200, 8'h04, 1'b0, '0, "R7 stale entry not written");
      probe(20'h00102, 8'h03, 1'b0, '0, "R7 flush still cleared");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule